// File: doc/BRIEF.md
# Parallel EEPROM Page-Burst Writer

This controller sits on the host side of a byte-wide parallel EEPROM and turns a request into a page-mode write burst. A request supplies a start address and a length. The bytes then follow on a valid/ready stream. For each byte the controller drives the bus and generates the chip-select, write-enable and output-enable strobes. Every setup, pulse and hold interval is a whole number of clock cycles, set by a parameter.

The device opens a page on the first write pulse. It keeps the page open only while each new write pulse arrives within a load window of the previous one. The controller holds chip select low for the whole burst and steps only the in-page offset bits. If the byte stream stalls for too long, the controller stops loading, because the next pulse could no longer land inside the window. In that case it reports a window error and treats the page as closed.

After the last loaded byte, the controller reads back that byte's address over and over. While the device is still programming, bit 7 of the read value comes back inverted. When bit 7 matches the written value, the controller raises `done`. A request that would run past the end of its page is refused. Polling that lasts too long is abandoned with a timeout flag.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, chip select, write enable and output enable are high (inactive), the data bus is not driven, and a request is accepted (`req_ready` high).
- R2: A request whose offset (the low `PB` address bits) plus `req_len` exceeds 2^PB-1 is refused with a one-cycle `err_boundary` pulse. Chip select stays high for that request.
- R3: `req_len` encodes the byte count minus one. Byte i of the stream is written to the start address plus i. Bytes are written in stream order.
- R4: Write enable stays low for at least `T_WP` cycles per byte. Within a burst it stays high for at least `T_WPH` cycles between pulses.
- R5: Address and write data are stable and driven for every cycle write enable is low, and for the cycle after it rises.
- R6: Output enable is high whenever write enable is low, in the cycle before write enable falls, and in the cycle after it rises.
- R7: Chip select is low whenever write enable or output enable is low. It stays low from the first byte through the end of polling.
- R8: The interval between consecutive write-enable falling edges in one burst never exceeds `WIN_CYC` cycles.
- R9: If the next byte is not offered in time to meet R8, no further byte is loaded. A one-cycle `err_window` pulse is raised, and polling starts on the last byte written.
- R10: Polling reads the last written address with output enable low for `T_RD` cycles per read. A single `done` pulse follows only once the read bit 7 equals the written bit 7.
- R11: If completion is not seen within `POLL_LIM` cycles of polling, `err_timeout` pulses, no `done` is given, and the controller returns to idle.
- R12: Address bits above the in-page offset do not change while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_addr | input | AW | Start address |
| req_len | input | PB | Byte count minus one |
| wr_valid | input | 1 | Stream byte present |
| wr_ready | output | 1 | Stream byte taken |
| wr_data | input | 8 | Stream byte |
| mem_addr | output | AW | EEPROM address |
| mem_dout | output | 8 | Write data to EEPROM |
| mem_dout_en | output | 1 | Drive enable for write data |
| mem_din | input | 8 | Read data from EEPROM |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| busy | output | 1 | Burst or polling in progress |
| done | output | 1 | One-cycle completion pulse |
| err_boundary | output | 1 | One-cycle page-crossing refusal |
| err_window | output | 1 | One-cycle load-window close |
| err_timeout | output | 1 | One-cycle polling timeout |

## Verification
The bench uses a 10-bit address, so its device model holds eight 128-byte pages. That lets it run a full 128-byte page, a single byte at offset 127, and bursts that end exactly at or cross past the page edge. The load window is shortened to 30 cycles and the poll limit to 200 cycles. With those values, a 100-cycle stream stall closes the window, and a device that stays busy forever reaches the poll timeout, both within a short run. Setup, pulse, recovery and read cycles are set to 2, 3, 2 and 2, so each strobe phase spans several cycles and its width can be measured.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int AW       = 17,
  parameter int PB       = 7,
  parameter int T_AS     = 1,
  parameter int T_WP     = 3,
  parameter int T_WPH    = 2,
  parameter int T_RD     = 2,
  parameter int WIN_CYC  = 12000,
  parameter int POLL_LIM = 1200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [PB-1:0] req_len,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [7:0]    wr_data,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_dout,
  output logic          mem_dout_en,
  input  logic [7:0]    mem_din,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          busy,
  output logic          done,
  output logic          err_boundary,
  output logic          err_window,
  output logic          err_timeout
);
  localparam int TW   = $clog2(T_AS + T_WP + T_WPH + T_RD + 1);
  localparam int WW   = $clog2(WIN_CYC + 1);
  localparam int PW   = $clog2(POLL_LIM + 1);
  localparam int WLIM = WIN_CYC - T_AS - 1;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SET, S_WLO, S_WHI, S_PRD, S_PGAP} st_t;

  st_t           st;
  logic [AW-1:0] addr;
  logic [7:0]    data;
  logic [PB-1:0] rem;
  logic [TW-1:0] tcnt;
  logic [WW-1:0] win;
  logic [PW-1:0] pcnt;
  logic          first;
  logic [PB:0]   span;

  assign span        = {1'b0, req_addr[PB-1:0]} + {1'b0, req_len};
  assign req_ready   = (st == S_IDLE);
  assign wr_ready    = (st == S_LOAD);
  assign busy        = (st != S_IDLE);
  assign mem_cs_n    = (st == S_IDLE);
  assign mem_we_n    = (st != S_WLO);
  assign mem_oe_n    = !(st == S_PRD);
  assign mem_dout_en = (st == S_SET) || (st == S_WLO) || (st == S_WHI);
  assign mem_addr    = addr;
  assign mem_dout    = data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr <= '0;
      data <= '0;
      rem <= '0;
      tcnt <= '0;
      win <= '0;
      pcnt <= '0;
      first <= 1'b1;
      done <= 1'b0;
      err_boundary <= 1'b0;
      err_window <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      err_boundary <= 1'b0;
      err_window <= 1'b0;
      err_timeout <= 1'b0;
      if (win != WW'(WIN_CYC)) win <= win + 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          if (span[PB]) err_boundary <= 1'b1;
          else begin
            addr <= req_addr;
            rem <= req_len;
            first <= 1'b1;
            st <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (wr_valid) begin
            data <= wr_data;
            if (!first) addr[PB-1:0] <= addr[PB-1:0] + 1'b1;
            first <= 1'b0;
            tcnt <= '0;
            st <= S_SET;
          end else if (!first && win >= WW'(WLIM)) begin
            err_window <= 1'b1;
            tcnt <= '0;
            pcnt <= '0;
            st <= S_PRD;
          end
        end
        S_SET: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == TW'(T_AS - 1)) begin
            tcnt <= '0;
            win <= '0;
            st <= S_WLO;
          end
        end
        S_WLO: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == TW'(T_WP - 1)) begin
            tcnt <= '0;
            st <= S_WHI;
          end
        end
        S_WHI: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == TW'(T_WPH - 1)) begin
            tcnt <= '0;
            if (rem == '0) begin
              pcnt <= '0;
              st <= S_PRD;
            end else begin
              rem <= rem - 1'b1;
              st <= S_LOAD;
            end
          end
        end
        S_PRD, S_PGAP: begin
          pcnt <= pcnt + 1'b1;
          if (st == S_PGAP) st <= S_PRD;
          else begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == TW'(T_RD - 1)) begin
              tcnt <= '0;
              st <= S_PGAP;
              if (mem_din[7] == data[7]) begin
                done <= 1'b1;
                st <= S_IDLE;
              end
            end
          end
          if (pcnt == PW'(POLL_LIM - 1) && !(st == S_PRD && tcnt == TW'(T_RD - 1) && mem_din[7] == data[7])) begin
            err_timeout <= 1'b1;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int AW      = 17,
  parameter int PB      = 7,
  parameter int T_WP    = 3,
  parameter int T_WPH   = 2,
  parameter int WIN_CYC = 12000
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_dout,
  input logic          mem_dout_en,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          done,
  input logic          err_boundary,
  input logic          err_window,
  input logic          err_timeout
);
  logic [31:0] lo_cnt, hi_cnt, gap;
  logic        prev_we, seen_rise, have_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0; hi_cnt <= '0; gap <= '0;
      prev_we <= 1'b1; seen_rise <= 1'b0; have_fall <= 1'b0;
    end else begin
      prev_we <= mem_we_n;
      lo_cnt <= mem_we_n ? '0 : lo_cnt + 1;
      hi_cnt <= mem_we_n ? hi_cnt + 1 : '0;
      if (mem_cs_n) begin
        seen_rise <= 1'b0; have_fall <= 1'b0; gap <= '0;
      end else begin
        if (mem_we_n && !prev_we) seen_rise <= 1'b1;
        if (!mem_we_n && prev_we) begin
          have_fall <= 1'b1; gap <= 32'd1;
        end else gap <= gap + 1;
      end
    end
  end

  assert_we_low_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && !prev_we) |-> lo_cnt >= T_WP);
  assert_we_high_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && prev_we && seen_rise) |-> hi_cnt >= T_WPH);
  assert_bus_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_we) |-> ($stable(mem_addr) && $stable(mem_dout) && mem_dout_en));
  assert_oe_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !prev_we) |-> mem_oe_n);
  assert_oe_before_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe_n && mem_we_n |=> (!mem_we_n |-> mem_oe_n));
  assert_cs_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> !mem_cs_n);
  assert_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && prev_we && have_fall) |-> gap <= WIN_CYC);
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_boundary, err_timeout}));
  assert_page_fixed_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr[AW-1:PB]));
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(
  .AW(AW), .PB(PB), .T_WP(T_WP), .T_WPH(T_WPH), .WIN_CYC(WIN_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
  .mem_dout_en(mem_dout_en), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .done(done), .err_boundary(err_boundary),
  .err_window(err_window), .err_timeout(err_timeout)
);

// File: tb/eeprom_page_writer_bench.sv
module eeprom_page_writer_bench;
  localparam int AW = 10, PB = 7, T_AS = 2, T_WP = 3, T_WPH = 2, T_RD = 2;
  localparam int WIN_CYC = 30, POLL_LIM = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, wr_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [PB-1:0] req_len = '0;
  logic [7:0] wr_data = '0;
  logic req_ready, wr_ready, mem_dout_en, mem_cs_n, mem_we_n, mem_oe_n;
  logic busy, done, err_boundary, err_window, err_timeout;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_dout, mem_din;

  always #2 clk = ~clk;

  eeprom_page_writer #(.AW(AW), .PB(PB), .T_AS(T_AS), .T_WP(T_WP), .T_WPH(T_WPH),
    .T_RD(T_RD), .WIN_CYC(WIN_CYC), .POLL_LIM(POLL_LIM)) u_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .busy(busy), .done(done), .err_boundary(err_boundary), .err_window(err_window),
    .err_timeout(err_timeout));

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] mem [0:(1<<AW)-1];
  logic [7:0] last_data = '0;
  logic [AW-1:0] last_addr = '0;
  int busy_cnt = 0, prog_cyc = 20;
  logic [AW+7:0] exp_q [$];

  assign mem_din = (!mem_oe_n && !mem_cs_n) ?
    ((busy_cnt > 0) ? ~last_data : mem[mem_addr]) : 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 29 + i * 53 + (i >> 2)) ^ (i << 5));
  endfunction

  // device model and monitor
  logic prev_we = 1'b1;
  int lo_w = 0, hi_w = 0;
  bit in_burst_rise = 0;
  always @(negedge clk) begin
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (!mem_we_n) begin
      check(mem_oe_n == 1'b1, "R6 oe high during write", mem_oe_n, 1);
      lo_w <= lo_w + 1;
    end else hi_w <= hi_w + 1;
    if (!mem_we_n && prev_we) begin
      if (in_burst_rise) check(hi_w >= T_WPH, "R4 we high width", hi_w, T_WPH);
      lo_w <= 1;
    end
    if (mem_we_n && !prev_we && !mem_cs_n) begin
      check(lo_w >= T_WP, "R4 we low width", lo_w, T_WP);
      mem[mem_addr] <= mem_dout;
      last_data <= mem_dout;
      last_addr <= mem_addr;
      busy_cnt <= prog_cyc;
      in_burst_rise <= 1;
      hi_w <= 1;
      if (exp_q.size() == 0) check(0, "R3 unexpected write", int'(mem_addr), 0);
      else begin
        logic [AW+7:0] e;
        e = exp_q.pop_front();
        check(e == {mem_addr, mem_dout}, "R3/R12 write addr+data", int'({mem_addr, mem_dout}), int'(e));
      end
    end
    if (mem_cs_n) in_burst_rise <= 0;
    if (!mem_oe_n) check(mem_addr == last_addr, "R10 poll address", int'(mem_addr), int'(last_addr));
    if (done) check(busy_cnt == 0, "R10 done only after true bit 7", busy_cnt, 0);
    prev_we <= mem_we_n;
  end

  task automatic burst(input logic [AW-1:0] a, input int len, input int nsend, input int seed,
                       input bit e_done, input bit e_bnd, input bit e_win, input bit e_to,
                       input string tag);
    bit s_done = 0, s_bnd = 0, s_win = 0, s_to = 0, s_cs = 0;
    bit acc = (int'(a[PB-1:0]) + len) < (1 << PB);
    if (acc) for (int i = 0; i < nsend; i++)
      exp_q.push_back({a + AW'(i), pat(seed, i)});
    @(negedge clk);
    req_valid = 1; req_addr = a; req_len = PB'(len);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (err_boundary) s_bnd = 1;
    if (acc) for (int i = 0; i < nsend; i++) begin
      wr_valid = 1; wr_data = pat(seed, i);
      while (!wr_ready) begin
        if (err_window) s_win = 1;
        @(negedge clk);
      end
      @(negedge clk);
      if (err_window) s_win = 1;
    end
    wr_valid = 0;
    for (int c = 0; c < 3000; c++) begin
      if (!mem_cs_n) s_cs = 1;
      if (done) s_done = 1;
      if (err_boundary) s_bnd = 1;
      if (err_window) s_win = 1;
      if (err_timeout) s_to = 1;
      if (s_done || s_to || (s_bnd && c > 20)) break;
      @(negedge clk);
    end
    check(s_done == e_done, {tag, " R10 done"}, s_done, e_done);
    check(s_bnd == e_bnd, {tag, " R2 boundary flag"}, s_bnd, e_bnd);
    check(s_win == e_win, {tag, " R9 window flag"}, s_win, e_win);
    check(s_to == e_to, {tag, " R11 timeout flag"}, s_to, e_to);
    if (e_bnd) check(!s_cs, {tag, " R2 cs stays high"}, s_cs, 0);
    check(exp_q.size() == 0, {tag, " R3 all bytes written"}, exp_q.size(), 0);
    if (e_done) for (int i = 0; i < nsend; i++)
      check(mem[a + AW'(i)] == pat(seed, i), {tag, " R3 stored byte"}, mem[a + AW'(i)], pat(seed, i));
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes idle in reset", {mem_cs_n, mem_we_n, mem_oe_n}, 7);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R1 req_ready after reset", req_ready, 1);
    check(mem_dout_en == 0, "R1 bus not driven", mem_dout_en, 0);
    burst(10'h10A, 3, 4, 1, 1, 0, 0, 0, "short");
    burst(10'h080, 127, 128, 2, 1, 0, 0, 0, "fullpage");
    burst(10'h07F, 0, 1, 3, 1, 0, 0, 0, "last-offset");
    burst(10'h17D, 2, 3, 4, 1, 0, 0, 0, "edge-fit");
    burst(10'h17E, 2, 3, 5, 0, 1, 0, 0, "cross");
    burst(10'h200, 9, 3, 6, 1, 0, 1, 0, "stall");
    check(mem[10'h203] == 8'hFF, "R9 no byte past stall", mem[10'h203], 8'hFF);
    prog_cyc = 100000;
    burst(10'h300, 0, 1, 7, 0, 0, 0, 1, "timeout");
    busy_cnt = 0; prog_cyc = 20;
    check(req_ready == 1, "R11 idle after timeout", req_ready, 1);
    burst(10'h3F0, 5, 6, 8, 1, 0, 0, 0, "after-timeout");
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule